// File: doc/BRIEF.md
# Path-Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating up/down counters. The low-order bits of the branch address pick a row of the table. A short shift register of recent global branch outcomes then picks one counter inside that row. Because each recent-outcome pattern has its own counter, a branch whose direction depends on the branches just before it is learned separately for each path that leads to it.

Fetch logic presents an address on the lookup side and receives a direction in the same cycle. That direction comes from the counter chosen by the current history. Fetch also reads the history value on `histOut` and keeps it with the branch. When the branch resolves, the resolve side returns four things: the address, the real outcome, whether the branch was conditional, and the saved history. The update then lands on the same counter that made the guess. With zero history bits, the block reduces to a plain per-address counter predictor.

Top module: `pathCorrPredictor`

## Requirements
- R1: `lookupTaken` is 1 exactly when the selected counter is at least 2^(CTR_BITS-1). With the default CTR_BITS=2, the values 2 and 3 give taken.
- R2: A conditional resolve adds one to the selected counter when the outcome is taken. It subtracts one when the outcome is not taken.
- R3: A counter at 2^CTR_BITS-1 stays there on a taken update. A counter at 0 stays there on a not-taken update. Counters never wrap.
- R4: Every resolve (`resValid`=1) shifts `histOut` left by one. The new bit enters at bit 0 and is `resTaken` for a conditional branch, or 1 for an unconditional one. Without a resolve, `histOut` holds.
- R5: The row is chosen only by address bits [IDX_BITS-1:0]. Addresses that differ only above those bits share a row.
- R6: Within a row, the lookup uses the counter numbered by the current `histOut`. Counters for different history values change independently.
- R7: A resolve updates the counter numbered by `resHist`, not the counter selected by the current history.
- R8: An unconditional resolve (`resCond`=0) changes no counter, whatever the value of `resTaken`.
- R9: Reset (`rstN`=0, synchronous) clears every counter to 0 and clears the history to 0.
- R10: When a lookup and a resolve address the same counter in one cycle, the lookup returns the value from before the update.
- R11: With HIST_BITS=0, each row holds one counter. That counter serves the row regardless of branch history, and `histOut` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupAddr | input | ADDR_W | Address of the branch being predicted |
| lookupTaken | output | 1 | Predicted direction, 1 = taken |
| histOut | output | max(HIST_BITS,1) | Current global outcome history, newest outcome in bit 0 |
| resValid | input | 1 | A branch resolves this cycle |
| resCond | input | 1 | 1 = conditional branch, 0 = unconditional |
| resTaken | input | 1 | Real outcome of the resolving branch |
| resAddr | input | ADDR_W | Address of the resolving branch |
| resHist | input | max(HIST_BITS,1) | History value captured when this branch was predicted |

## Verification
The sequence drives one counter to the top and pushes further taken updates into it, then walks it back down. A counter that wraps instead of saturating would report taken when the bench expects not-taken. An unconditional resolve with a not-taken outcome lands on a counter that holds 2. A design that updated on it would lower that counter, and a later prediction would flip. Resolves carry a history that differs from the live one, so a design that indexed updates by the live history would train the wrong counter. A same-cycle lookup and update of one counter must return the old value; a write-through design would report the new one. A high-address alias checks that only the low bits pick the row. A second instance with no history bits must act as a single counter per address.

// File: rtl/predPkg.sv
package predPkg;
  typedef struct packed {
    logic ctrWrite;
    logic ctrInc;
    logic histShift;
    logic histBit;
  } predStrobe_t;
endpackage

// File: rtl/predCtrl.sv
module predCtrl
  import predPkg::*;
(
  input  logic        resValid,
  input  logic        resCond,
  input  logic        resTaken,
  output predStrobe_t strobe
);
  always_comb begin
    strobe.ctrWrite  = resValid & resCond;
    strobe.ctrInc    = resTaken;
    strobe.histShift = resValid;
    strobe.histBit   = ~resCond | resTaken;
  end
endmodule

// File: rtl/predData.sv
module predData
  import predPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_BITS  = 8,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  localparam int HW       = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  predStrobe_t       strobe,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] resAddr,
  input  logic [HW-1:0]     resHist,
  output logic              lookupTaken,
  output logic [HW-1:0]     histOut
);
  localparam int ENTRIES = 1 << (IDX_BITS + HIST_BITS);
  localparam int EW      = IDX_BITS + HIST_BITS;
  localparam logic [CTR_BITS-1:0] THR  = CTR_BITS'(1) << (CTR_BITS - 1);
  localparam logic [CTR_BITS-1:0] MAXC = '1;

  logic [CTR_BITS-1:0] ctrTab [ENTRIES];
  logic [HW-1:0]       histQ;
  logic [EW-1:0]       rdIdx;
  logic [EW-1:0]       wrIdx;
  logic [CTR_BITS-1:0] curVal;
  logic [CTR_BITS-1:0] nextVal;

  generate
    if (HIST_BITS > 0) begin : g_corr
      assign rdIdx = {lookupAddr[IDX_BITS-1:0], histQ};
      assign wrIdx = {resAddr[IDX_BITS-1:0], resHist};
      always_ff @(posedge clk) begin
        if (!rstN)                 histQ <= '0;
        else if (strobe.histShift) histQ <= (histQ << 1) | HW'(strobe.histBit);
      end
    end else begin : g_flat
      assign rdIdx = lookupAddr[IDX_BITS-1:0];
      assign wrIdx = resAddr[IDX_BITS-1:0];
      assign histQ = '0;
    end
  endgenerate

  always_comb begin
    curVal = ctrTab[wrIdx];
    if (strobe.ctrInc) nextVal = (curVal == MAXC) ? curVal : curVal + 1'b1;
    else               nextVal = (curVal == '0)   ? curVal : curVal - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) ctrTab[e] <= '0;
    end else if (strobe.ctrWrite) begin
      ctrTab[wrIdx] <= nextVal;
    end
  end

  assign lookupTaken = (ctrTab[rdIdx] >= THR);
  assign histOut     = histQ;
endmodule

// File: rtl/pathCorrPredictor.sv
module pathCorrPredictor
  import predPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_BITS  = 8,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  localparam int HW       = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupTaken,
  output logic [HW-1:0]     histOut,
  input  logic              resValid,
  input  logic              resCond,
  input  logic              resTaken,
  input  logic [ADDR_W-1:0] resAddr,
  input  logic [HW-1:0]     resHist
);
  predStrobe_t strobe;

  predCtrl u_ctrl (
    .resValid(resValid), .resCond(resCond), .resTaken(resTaken), .strobe(strobe)
  );

  predData #(
    .ADDR_W(ADDR_W), .IDX_BITS(IDX_BITS), .HIST_BITS(HIST_BITS), .CTR_BITS(CTR_BITS)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupAddr(lookupAddr),
    .resAddr(resAddr), .resHist(resHist), .lookupTaken(lookupTaken), .histOut(histOut)
  );
endmodule

// File: rtl/pathCorrPredictorChk.sv
module pathCorrPredictorChk #(
  parameter int HIST_BITS = 2,
  localparam int HW       = (HIST_BITS > 0) ? HIST_BITS : 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          resValid,
  input logic          resCond,
  input logic          resTaken,
  input logic          lookupTaken,
  input logic [HW-1:0] histOut
);
  // R9
  reset_hist_chk: assert property (@(posedge clk) !rstN |=> histOut == '0);

  // R1
  pred_known_chk: assert property (@(posedge clk) disable iff (!rstN) !$isunknown(lookupTaken));

  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |=> $stable(histOut));

  generate
    if (HIST_BITS > 0) begin : g_shift
      // R4
      hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
        resValid |=> histOut == HW'({$past(histOut), $past(~resCond | resTaken)}));
    end else begin : g_none
      // R11
      hist_zero_chk: assert property (@(posedge clk) disable iff (!rstN) histOut == '0);
    end
  endgenerate
endmodule

bind pathCorrPredictor pathCorrPredictorChk #(.HIST_BITS(HIST_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .resValid(resValid), .resCond(resCond),
  .resTaken(resTaken), .lookupTaken(lookupTaken), .histOut(histOut)
);

// File: tb/sim_pathCorrPredictor.sv
`timescale 1ns/1ps
module sim_pathCorrPredictor;
  logic clk = 0;
  logic rstN = 0;
  always #2.5 clk = ~clk;

  logic [31:0] lookupAddr = '0, resAddr = '0;
  logic        lookupTaken, resValid = 0, resCond = 0, resTaken = 0;
  logic [1:0]  histOut, resHist = '0;

  pathCorrPredictor u0 (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .lookupTaken(lookupTaken),
    .histOut(histOut), .resValid(resValid), .resCond(resCond), .resTaken(resTaken),
    .resAddr(resAddr), .resHist(resHist)
  );

  logic [31:0] fAddr = '0, fResAddr = '0;
  logic        fTaken, fValid = 0, fCond = 0, fResTaken = 0;
  logic [0:0]  fHist, fResHist = '0;

  pathCorrPredictor #(.HIST_BITS(0)) u1 (
    .clk(clk), .rstN(rstN), .lookupAddr(fAddr), .lookupTaken(fTaken),
    .histOut(fHist), .resValid(fValid), .resCond(fCond), .resTaken(fResTaken),
    .resAddr(fResAddr), .resHist(fResHist)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {valid, cond, taken, resAddr[11:0], resHist, lookupAddr[11:0], expPred, expHistAfter}
  localparam int NV = 15;
  localparam logic [31:0] VEC [NV] = '{
    {3'b111, 12'h010, 2'd0, 12'h010, 1'b0, 2'd1}, // R2 R6 first taken at h0
    {3'b111, 12'h010, 2'd0, 12'h010, 1'b0, 2'd3}, // R7 update uses resHist 0 while live hist is 1
    {3'b100, 12'h010, 2'd0, 12'h110, 1'b0, 2'd3}, // R8 R4 unconditional, taken=0, shifts 1
    {3'b110, 12'h020, 2'd0, 12'h010, 1'b0, 2'd2}, // R3 not-taken at zero
    {3'b110, 12'h020, 2'd0, 12'h010, 1'b0, 2'd0}, // R6 other history counter still 0
    {3'b000, 12'h000, 2'd0, 12'h010, 1'b1, 2'd0}, // R1 counter=2 predicts taken
    {3'b111, 12'h010, 2'd0, 12'h310, 1'b1, 2'd1}, // R5 alias of row 0x10
    {3'b111, 12'h010, 2'd0, 12'h020, 1'b0, 2'd3}, // R3 taken at max stays 3
    {3'b110, 12'h010, 2'd0, 12'h010, 1'b0, 2'd2}, // R2 3->2
    {3'b110, 12'h010, 2'd0, 12'h010, 1'b0, 2'd0}, // R2 2->1
    {3'b000, 12'h000, 2'd0, 12'h010, 1'b0, 2'd0}, // R3 R1 counter=1 not taken
    {3'b111, 12'h010, 2'd0, 12'h010, 1'b0, 2'd1}, // R10 same counter: old value 1
    {3'b110, 12'h040, 2'd1, 12'h010, 1'b0, 2'd2}, // R6 hist 1 counter is 0
    {3'b110, 12'h040, 2'd0, 12'h010, 1'b0, 2'd0}, // R6 hist 2 counter is 0
    {3'b000, 12'h000, 2'd0, 12'h010, 1'b1, 2'd0}  // R10 update landed: counter=2
  };

  task automatic fstep(bit v, bit c, bit t, logic [31:0] a);
    @(negedge clk);
    fValid = v; fCond = c; fResTaken = t; fResAddr = a; fAddr = 32'h10;
    @(posedge clk); #1;
    fValid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    lookupAddr = 32'h10;
    #1;
    check("R9 pred after reset", lookupTaken, 0);
    check("R9 hist after reset", histOut, 0);
    rstN = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      resValid   = VEC[i][31];
      resCond    = VEC[i][30];
      resTaken   = VEC[i][29];
      resAddr    = {20'h0, VEC[i][28:17]};
      resHist    = VEC[i][16:15];
      lookupAddr = {20'h0, VEC[i][14:3]};
      #1;
      check($sformatf("R1 R6 vector %0d prediction", i), lookupTaken, VEC[i][2]);
      @(posedge clk); #1;
      check($sformatf("R4 vector %0d history", i), histOut, VEC[i][1:0]);
    end
    @(negedge clk);
    resValid = 0;

    // R9: reset mid-run clears counters and history
    @(negedge clk); rstN = 0;
    @(posedge clk); #1;
    @(negedge clk); rstN = 1; lookupAddr = 32'h10; #1;
    check("R9 counter cleared", lookupTaken, 0);
    check("R9 history cleared", histOut, 0);

    // R11: zero-history instance acts as one counter per row
    fstep(1, 1, 1, 32'h10);
    check("R11 after one taken", fTaken, 0);
    fstep(1, 0, 0, 32'h10);
    check("R11 unconditional keeps counter", fTaken, 0);
    check("R11 history stays zero", fHist, 0);
    fstep(1, 1, 1, 32'h10);
    check("R11 after two taken", fTaken, 1);
    fAddr = 32'hF10; #1;
    check("R11 R5 alias row", fTaken, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule